// File: doc/BRIEF.md
# Feature Header Chain Walker

This block enumerates the features of a memory-mapped device by following a linked chain of 64-bit feature headers. A one-cycle start pulse supplies a base byte address. The walker then issues single-word reads through a request/response port, with only one read in flight at a time. It decodes each header it reaches and emits one record per feature on a valid/ready output. A feature record carries the feature type, feature ID, revision, 128-bit GUID and resolved register base address.

Headers come in two layouts, selected by the version byte of word 0. Version-1 headers carry extra words that locate the register block. They may also carry a chain of parameter blocks, and the walker emits one record per parameter with its ID, version and data address. Headers are linked by byte offsets, and parameter blocks are linked by 8-byte-word offsets. Each chain has its own end flag. Malformed chains end the walk with an error instead of looping. A walk also ends with an error when a configurable feature limit is reached.

A single-cycle done pulse follows the last record. During that pulse the error flag and the feature count are valid, and both stay valid until the next start.

Top module: `hdr_chain_walker`

## Requirements
- R1: A start pulse while idle begins a walk at base_addr and raises busy. A start pulse while busy has no effect on the records or on the outcome of the current walk. While idle, no read request and no record is presented.
- R2: At most one read is outstanding. A request holds its valid and address until it is accepted. No new request is raised while a response is still owed.
- R3: Header word 0 (offset 0) is decoded with the type in bits 63:60, the version in 59:52, the end-of-list flag in bit 40, the next offset in 39:16, the revision in 15:12 and the feature ID in 11:0. The feature record gives the type, the ID zero-extended to 16 bits and the revision zero-extended to 16 bits, and has is_param low.
- R4: The GUID is read from offset 0x08 (low half) and offset 0x10 (high half). This happens for every version-1 header, and for version-0 headers whose type is 1 or 4. For any other version-0 type the GUID is reported as zero.
- R5: The next offset is added in bytes to the current header address. A header with the end-of-list flag set is the last one visited, whatever its next field holds.
- R6: A version-0 feature reports its own header address as register base. For a version-1 feature, let W be the word at offset 0x18. If W bit 0 is 1, the base is W with bit 0 cleared. If W bit 0 is 0, the base is the header address plus W with bit 0 cleared.
- R7: For a version-1 feature whose word at offset 0x20 has bit 31 set, parameter blocks are walked, starting at header address plus 0x28, after that feature's record. Each block emits a record with is_param high, the ID from bits 15:0 in rec_id, the version from bits 31:16 in rec_rev, and the block address plus 8 in rec_addr. The record carries the parent feature's type and GUID.
- R8: A parameter block's next field (bits 63:35) counts 8-byte words from the block address. A block with bit 32 set is the last block of its feature.
- R9: A header whose version is neither 0 nor 1 ends the walk with err high and emits no record for that header. The count is the number of features emitted before it.
- R10: A next field of zero in a header without end-of-list, or in a parameter block without the end bit, ends the walk with err high.
- R11: After MAX_FEAT feature records, a header that is not end-of-list ends the walk with err high and a count of MAX_FEAT.
- R12: A record holds stable while rec_ready is low. done is a one-cycle pulse after the last record, and busy is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| base_addr | input | 64 | Byte address of the first header |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk ended on a malformed chain or the limit |
| feat_count | output | $clog2(MAX_FEAT+1) | Features emitted in the last walk |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted |
| rec_is_param | output | 1 | 1 for a parameter record, 0 for a feature record |
| rec_type | output | 4 | Feature type |
| rec_id | output | 16 | Feature ID or parameter ID |
| rec_rev | output | 16 | Feature revision or parameter version |
| rec_guid | output | 128 | Feature GUID |
| rec_addr | output | 64 | Register base or parameter data address |

## Verification
The checks assume the read port returns exactly one response per accepted request, at least one cycle after acceptance and never unprompted. They also assume start is a single-cycle pulse. The bench's memory responder accepts requests on a pseudo-random ready, answers each one after a fixed two-cycle delay and never raises a response on its own. The bench drives start for exactly one cycle, including the extra pulse it sends in the middle of a walk. Record backpressure is applied pseudo-randomly on some walks, so the hold property is exercised while the responder still keeps to these rules.

// File: rtl/hcw_pkg.sv
package hcw_pkg;

    localparam int AW = 64;
    localparam int WW = 64;

    // word offsets inside a header, in bytes
    localparam logic [AW-1:0] OFS_GUID_LO = 64'h08;
    localparam logic [AW-1:0] OFS_GUID_HI = 64'h10;
    localparam logic [AW-1:0] OFS_LOCATE  = 64'h18;
    localparam logic [AW-1:0] OFS_SHAPE   = 64'h20;
    localparam logic [AW-1:0] OFS_PARAMS  = 64'h28;
    localparam logic [AW-1:0] PARAM_DATA  = 64'h08;
    localparam int            SHAPE_PFLAG = 31;

    // version-0 types that carry a GUID
    localparam logic [3:0] TYPE_GUID_A = 4'd1;
    localparam logic [3:0] TYPE_GUID_B = 4'd4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_W0, ST_GLO, ST_GHI, ST_LOC, ST_SIZE,
        ST_FEMIT, ST_PHDR, ST_PEMIT, ST_ADV, ST_FIN
    } walk_st_e;

    typedef enum logic [1:0] { V_NEXT, V_END, V_FAIL } verdict_e;

    typedef struct packed {
        logic [3:0]  ftype;
        logic [7:0]  hver;
        logic        eol;
        logic [23:0] nxt;
        logic [3:0]  rev;
        logic [11:0] fid;
    } hdr_t;

    typedef struct packed {
        logic [28:0] nxt;
        logic        eop;
        logic [15:0] pver;
        logic [15:0] pid;
    } prm_t;

    typedef struct packed {
        logic         is_param;
        logic [3:0]   ftype;
        logic [15:0]  id;
        logic [15:0]  rev;
        logic [127:0] guid;
        logic [AW-1:0] addr;
    } rec_t;

    function automatic hdr_t unpack_hdr(input logic [WW-1:0] w);
        hdr_t h;
        h.ftype = w[63:60];
        h.hver  = w[59:52];
        h.eol   = w[40];
        h.nxt   = w[39:16];
        h.rev   = w[15:12];
        h.fid   = w[11:0];
        return h;
    endfunction

    function automatic prm_t unpack_prm(input logic [WW-1:0] w);
        prm_t p;
        p.nxt  = w[63:35];
        p.eop  = w[32];
        p.pver = w[31:16];
        p.pid  = w[15:0];
        return p;
    endfunction

    function automatic logic guid_in_v0(input logic [3:0] t);
        return (t == TYPE_GUID_A) || (t == TYPE_GUID_B);
    endfunction

    function automatic logic [AW-1:0] resolve_base(input logic [AW-1:0] hdr_at,
                                                   input logic [WW-1:0] loc);
        logic [AW-1:0] v;
        v = {loc[WW-1:1], 1'b0};
        return loc[0] ? v : hdr_at + v;
    endfunction

endpackage

// File: rtl/hcw_reader.sv
module hcw_reader
    import hcw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    output logic          idle,
    output logic          hit,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid
);
    logic req_q, wait_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            wait_q <= 1'b0;
            addr_q <= '0;
        end else begin
            if (go && !req_q && !wait_q) begin
                req_q  <= 1'b1;
                addr_q <= go_addr;
            end
            if (req_q && rd_req_ready) begin
                req_q  <= 1'b0;
                wait_q <= 1'b1;
            end
            if (wait_q && rd_rsp_valid) begin
                wait_q <= 1'b0;
            end
        end
    end

    assign idle         = !req_q && !wait_q;
    assign hit          = wait_q && rd_rsp_valid;
    assign rd_req_valid = req_q;
    assign rd_req_addr  = addr_q;
endmodule

// File: rtl/hcw_adv_judge.sv
module hcw_adv_judge
    import hcw_pkg::*;
#(
    parameter int MAX_FEAT = 64,
    localparam int CW = $clog2(MAX_FEAT + 1)
) (
    input  logic          eol,
    input  logic [23:0]   nxt,
    input  logic [CW-1:0] cnt,
    output verdict_e      verdict
);
    always_comb begin
        if (eol)
            verdict = V_END;
        else if (nxt == '0)
            verdict = V_FAIL;
        else if (cnt >= CW'(MAX_FEAT))
            verdict = V_FAIL;
        else
            verdict = V_NEXT;
    end
endmodule

// File: rtl/hcw_walk_ctl.sv
module hcw_walk_ctl
    import hcw_pkg::*;
#(
    parameter int MAX_FEAT = 64,
    localparam int CW = $clog2(MAX_FEAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_idle,
    input  logic          rd_hit,
    input  logic [WW-1:0] rd_data,
    output logic          rec_valid,
    input  logic          rec_ready,
    output rec_t          rec,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] feat_count
);
    walk_st_e      st;
    hdr_t          hdr;
    prm_t          prm;
    hdr_t          w0_dec;
    logic [AW-1:0] hdr_addr, prm_addr, reg_base;
    logic [127:0]  guid;
    logic          pflag, issued, err_q, reading;
    logic [CW-1:0] cnt;
    verdict_e      verdict;

    assign w0_dec = unpack_hdr(rd_data);

    hcw_adv_judge #(.MAX_FEAT(MAX_FEAT)) u_judge (
        .eol    (hdr.eol),
        .nxt    (hdr.nxt),
        .cnt    (cnt),
        .verdict(verdict)
    );

    always_comb begin
        reading = 1'b1;
        rd_addr = hdr_addr;
        unique case (st)
            ST_W0:   rd_addr = hdr_addr;
            ST_GLO:  rd_addr = hdr_addr + OFS_GUID_LO;
            ST_GHI:  rd_addr = hdr_addr + OFS_GUID_HI;
            ST_LOC:  rd_addr = hdr_addr + OFS_LOCATE;
            ST_SIZE: rd_addr = hdr_addr + OFS_SHAPE;
            ST_PHDR: rd_addr = prm_addr;
            default: reading = 1'b0;
        endcase
    end

    assign rd_go = reading && rd_idle && !issued;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            hdr      <= '0;
            prm      <= '0;
            hdr_addr <= '0;
            prm_addr <= '0;
            reg_base <= '0;
            guid     <= '0;
            pflag    <= 1'b0;
            issued   <= 1'b0;
            err_q    <= 1'b0;
            cnt      <= '0;
        end else begin
            if (rd_go)  issued <= 1'b1;
            if (rd_hit) issued <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    hdr_addr <= base_addr;
                    cnt      <= '0;
                    err_q    <= 1'b0;
                    st       <= ST_W0;
                end
                ST_W0: if (rd_hit) begin
                    hdr   <= w0_dec;
                    guid  <= '0;
                    pflag <= 1'b0;
                    if (w0_dec.hver > 8'd1) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else if (w0_dec.hver == 8'd1 || guid_in_v0(w0_dec.ftype)) begin
                        st <= ST_GLO;
                    end else begin
                        reg_base <= hdr_addr;
                        st       <= ST_FEMIT;
                    end
                end
                ST_GLO: if (rd_hit) begin
                    guid[63:0] <= rd_data;
                    st         <= ST_GHI;
                end
                ST_GHI: if (rd_hit) begin
                    guid[127:64] <= rd_data;
                    if (hdr.hver == 8'd1) begin
                        st <= ST_LOC;
                    end else begin
                        reg_base <= hdr_addr;
                        st       <= ST_FEMIT;
                    end
                end
                ST_LOC: if (rd_hit) begin
                    reg_base <= resolve_base(hdr_addr, rd_data);
                    st       <= ST_SIZE;
                end
                ST_SIZE: if (rd_hit) begin
                    pflag <= rd_data[SHAPE_PFLAG];
                    st    <= ST_FEMIT;
                end
                ST_FEMIT: if (rec_ready) begin
                    cnt <= cnt + 1'b1;
                    if (pflag) begin
                        prm_addr <= hdr_addr + OFS_PARAMS;
                        st       <= ST_PHDR;
                    end else begin
                        st <= ST_ADV;
                    end
                end
                ST_PHDR: if (rd_hit) begin
                    prm <= unpack_prm(rd_data);
                    st  <= ST_PEMIT;
                end
                ST_PEMIT: if (rec_ready) begin
                    if (prm.eop) begin
                        st <= ST_ADV;
                    end else if (prm.nxt == '0) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else begin
                        prm_addr <= prm_addr + {32'b0, prm.nxt, 3'b000};
                        st       <= ST_PHDR;
                    end
                end
                ST_ADV: begin
                    unique case (verdict)
                        V_END:   st <= ST_FIN;
                        V_FAIL:  begin err_q <= 1'b1; st <= ST_FIN; end
                        default: begin
                            hdr_addr <= hdr_addr + {40'b0, hdr.nxt};
                            st       <= ST_W0;
                        end
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rec.is_param = (st == ST_PEMIT);
        rec.ftype    = hdr.ftype;
        rec.guid     = guid;
        rec.id       = rec.is_param ? prm.pid  : {4'b0, hdr.fid};
        rec.rev      = rec.is_param ? prm.pver : {12'b0, hdr.rev};
        rec.addr     = rec.is_param ? prm_addr + PARAM_DATA : reg_base;
    end

    assign rec_valid  = (st == ST_FEMIT) || (st == ST_PEMIT);
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_FIN);
    assign err        = err_q;
    assign feat_count = cnt;
endmodule

// File: rtl/hdr_chain_walker.sv
module hdr_chain_walker
    import hcw_pkg::*;
#(
    parameter int MAX_FEAT = 64,
    localparam int CW = $clog2(MAX_FEAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [63:0]   base_addr,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] feat_count,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [63:0]   rd_req_addr,
    input  logic          rd_rsp_valid,
    input  logic [63:0]   rd_rsp_data,
    output logic          rec_valid,
    input  logic          rec_ready,
    output logic          rec_is_param,
    output logic [3:0]    rec_type,
    output logic [15:0]   rec_id,
    output logic [15:0]   rec_rev,
    output logic [127:0]  rec_guid,
    output logic [63:0]   rec_addr
);
    logic          rd_go, rd_idle, rd_hit;
    logic [AW-1:0] rd_addr;
    rec_t          rec;

    hcw_reader u_reader (
        .clk         (clk),
        .rst         (rst),
        .go          (rd_go),
        .go_addr     (rd_addr),
        .idle        (rd_idle),
        .hit         (rd_hit),
        .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready),
        .rd_req_addr (rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid)
    );

    hcw_walk_ctl #(.MAX_FEAT(MAX_FEAT)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_addr (base_addr),
        .rd_go     (rd_go),
        .rd_addr   (rd_addr),
        .rd_idle   (rd_idle),
        .rd_hit    (rd_hit),
        .rd_data   (rd_rsp_data),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec       (rec),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .feat_count(feat_count)
    );

    assign rec_is_param = rec.is_param;
    assign rec_type     = rec.ftype;
    assign rec_id       = rec.id;
    assign rec_rev      = rec.rev;
    assign rec_guid     = rec.guid;
    assign rec_addr     = rec.addr;
endmodule

// File: rtl/hcw_checker.sv
module hcw_checker #(
    parameter int MAX_FEAT = 64,
    localparam int CW = $clog2(MAX_FEAT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] feat_count,
    input logic          rd_req_valid,
    input logic          rd_req_ready,
    input logic [63:0]   rd_req_addr,
    input logic          rd_rsp_valid,
    input logic          rec_valid,
    input logic          rec_ready,
    input logic [15:0]   rec_id,
    input logic [63:0]   rec_addr
);
    // reads owed by the environment, tracked from the port handshakes
    logic [1:0] owed;
    always_ff @(posedge clk) begin
        if (rst)
            owed <= '0;
        else
            owed <= owed + {1'b0, rd_req_valid && rd_req_ready} - {1'b0, rd_rsp_valid};
    end

    p_single_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
        owed <= 2'd1);

    p_no_req_while_owed_r2: assert property (@(posedge clk) disable iff (rst)
        owed == 2'd1 |-> !rd_req_valid);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    p_rsp_expected_r2: assert property (@(posedge clk) disable iff (rst)
        rd_rsp_valid |-> owed == 2'd1);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rec_valid && !rd_req_valid);

    p_start_while_busy_r1: assert property (@(posedge clk) disable iff (rst)
        busy && !done && start |=> busy);

    p_rec_hold_r12: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_id) && $stable(rec_addr));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        feat_count <= CW'(MAX_FEAT));
endmodule

bind hdr_chain_walker hcw_checker #(.MAX_FEAT(MAX_FEAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .feat_count  (feat_count),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_id      (rec_id),
    .rec_addr    (rec_addr)
);

// File: tb/hdr_chain_walker_test.sv
module hdr_chain_walker_test;
    localparam int MAXF = 4;
    localparam int CW   = $clog2(MAXF + 1);
    localparam int LAT  = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [63:0]   base_addr = '0;
    logic          busy, done, err;
    logic [CW-1:0] feat_count;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [63:0]   rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [63:0]   rd_rsp_data = '0;
    logic          rec_valid;
    logic          rec_ready = 1'b0;
    logic          rec_is_param;
    logic [3:0]    rec_type;
    logic [15:0]   rec_id, rec_rev;
    logic [127:0]  rec_guid;
    logic [63:0]   rec_addr;

    hdr_chain_walker #(.MAX_FEAT(MAXF)) uut (.*);

    typedef struct {
        bit         is_param;
        bit [3:0]   ftype;
        bit [15:0]  id;
        bit [15:0]  rev;
        bit [127:0] guid;
        bit [63:0]  addr;
    } exp_rec_t;

    exp_rec_t    exp_q[$];
    bit          exp_err;
    int          exp_cnt;
    logic [63:0] mem [bit [63:0]];
    int          n_chk = 0, n_fail = 0;
    bit          bp_mode = 1'b0;
    bit          saw_done = 1'b0, done_err = 1'b0;
    int          done_cnt = 0;
    bit [15:0]   lfsr = 16'hACE1;
    int          pend = 0;
    bit          owed = 1'b0;
    logic [63:0] pend_addr = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [63:0] rdm(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] hw(input int t, input int ver, input bit eol,
                                       input int nxt, input int rev, input int fid);
        return {t[3:0], ver[7:0], 11'b0, eol, nxt[23:0], rev[3:0], fid[11:0]};
    endfunction

    function automatic logic [63:0] pw(input int nxt, input bit eop,
                                       input int pver, input int pid);
        return {nxt[28:0], 2'b00, eop, pver[15:0], pid[15:0]};
    endfunction

    // behavioural model of the walk over the bench memory
    task automatic model(input logic [63:0] base);
        logic [63:0] h, w, l, p, q, b;
        logic [127:0] g;
        int cnt, ver, t;
        bit pf, stop;
        exp_rec_t r;
        h = base; cnt = 0; exp_err = 0; stop = 0;
        for (int guard = 0; guard < 100 && !stop; guard++) begin
            w = rdm(h); ver = int'(w[59:52]); t = int'(w[63:60]);
            if (ver > 1) begin exp_err = 1; break; end
            g = '0;
            if (ver == 1 || t == 1 || t == 4) g = {rdm(h + 64'h10), rdm(h + 64'h08)};
            pf = 0; b = h;
            if (ver == 1) begin
                l = rdm(h + 64'h18);
                b = l[0] ? {l[63:1], 1'b0} : h + {l[63:1], 1'b0};
                pf = rdm(h + 64'h20)[31];
            end
            r.is_param = 0; r.ftype = w[63:60]; r.id = {4'b0, w[11:0]};
            r.rev = {12'b0, w[15:12]}; r.guid = g; r.addr = b;
            exp_q.push_back(r); cnt++;
            if (pf) begin
                p = h + 64'h28;
                for (int k = 0; k < 100; k++) begin
                    q = rdm(p);
                    r.is_param = 1; r.id = q[15:0]; r.rev = q[31:16]; r.addr = p + 64'h8;
                    exp_q.push_back(r);
                    if (q[32]) break;
                    if (q[63:35] == 0) begin exp_err = 1; stop = 1; break; end
                    p = p + {32'b0, q[63:35], 3'b000};
                end
            end
            if (stop) break;
            if (w[40]) break;
            if (w[39:16] == 0) begin exp_err = 1; break; end
            if (cnt >= MAXF) begin exp_err = 1; break; end
            h = h + {40'b0, w[39:16]};
        end
        exp_cnt = cnt;
    endtask

    // environment: memory responder, record sink, done monitor
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            rd_req_ready = 0; rd_rsp_valid = 0; rec_ready = 0; pend = 0; owed = 0;
        end else begin
            rd_rsp_valid = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_rsp_valid = 1; rd_rsp_data = rdm(pend_addr); owed = 0;
                end
            end
            if (rd_req_valid && owed)
                check(0, "R2", "request while response owed", 1, 0);
            rd_req_ready = lfsr[0] | lfsr[3];
            rec_ready    = bp_mode ? lfsr[5] : 1'b1;
            if (rd_req_valid && rd_req_ready) begin
                owed = 1; pend = LAT; pend_addr = rd_req_addr;
            end
            if (rec_valid && rec_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R12", "unexpected record", {64'b0, rec_addr}, 0);
                end else begin
                    exp_rec_t e;
                    e = exp_q.pop_front();
                    check(rec_is_param == e.is_param, "R7", "record kind", rec_is_param, e.is_param);
                    check(rec_type == e.ftype && rec_id == e.id && rec_rev == e.rev,
                          e.is_param ? "R8" : "R3", "type/id/rev",
                          {rec_type, rec_id, rec_rev}, {e.ftype, e.id, e.rev});
                    check(rec_guid == e.guid, "R4", "guid", rec_guid, e.guid);
                    check(rec_addr == e.addr, e.is_param ? "R7" : "R6", "address",
                          rec_addr, e.addr);
                end
            end
            if (done) begin
                saw_done = 1; done_err = err; done_cnt = int'(feat_count);
            end
        end
    end

    task automatic run_walk(input logic [63:0] base, input string tag,
                            input bit poke, input logic [63:0] poke_base);
        int t;
        exp_q.delete();
        model(base);
        saw_done = 0;
        @(negedge clk); start = 1; base_addr = base;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (6) @(negedge clk);
            check(busy, "R1", "busy before second start", busy, 1);
            start = 1; base_addr = poke_base;
            @(negedge clk); start = 0;
        end
        t = 0;
        while (!saw_done && t < 5000) begin @(posedge clk); t++; end
        check(saw_done, tag, "watchdog: no done", saw_done, 1);
        check(exp_q.size() == 0, "R12", "records missing at done", exp_q.size(), 0);
        check(done_err == exp_err, tag, "err at done", done_err, exp_err);
        check(done_cnt == exp_cnt, tag, "count at done", done_cnt, exp_cnt);
        @(negedge clk);
        check(!busy && !done, "R12", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !done && !rec_valid && !rd_req_valid, "R1", "reset state",
              {busy, done, rec_valid, rd_req_valid}, 0);

        // version-0 chain: GUID types and a private type, then end-of-list (R3 R4 R5 R6)
        mem.delete();
        mem[64'h1000] = hw(1, 0, 0, 'h100, 3, 'h12);
        mem[64'h1008] = 64'h1111_2222_3333_4444;
        mem[64'h1010] = 64'h5555_6666_7777_8888;
        mem[64'h1100] = hw(3, 0, 0, 'h40, 1, 'h7);
        mem[64'h1108] = 64'hDEAD_BEEF_0000_0001;
        mem[64'h1110] = 64'hDEAD_BEEF_0000_0002;
        mem[64'h1140] = hw(4, 0, 1, 'h200, 9, 'hABC);
        mem[64'h1148] = 64'hAAAA_0000_0000_0001;
        mem[64'h1150] = 64'hBBBB_0000_0000_0002;
        run_walk(64'h1000, "R5", 0, 0);
        check(exp_cnt == 3, "R5", "three features by end flag", exp_cnt, 3);

        // version-1 with relative base and parameters, then absolute base (R6 R7 R8)
        mem.delete();
        mem[64'h20000] = hw(3, 1, 0, 'h1000, 2, 'h21);
        mem[64'h20008] = 64'h0123_4567_89AB_CDEF;
        mem[64'h20010] = 64'hFEDC_BA98_7654_3210;
        mem[64'h20018] = 64'h800;
        mem[64'h20020] = 64'h0000_0100_8000_0000;
        mem[64'h20028] = pw(3, 0, 1, 5);
        mem[64'h20040] = pw(2, 0, 2, 6);
        mem[64'h20050] = pw(4, 1, 3, 7);
        mem[64'h21000] = hw(2, 1, 1, 'h80, 1, 'h22);
        mem[64'h21008] = 64'h1;
        mem[64'h21010] = 64'h2;
        mem[64'h21018] = 64'h0000_ABCD_0000_1001;
        mem[64'h21020] = 64'h0000_0040_0000_0000;
        bp_mode = 1;
        run_walk(64'h20000, "R8", 0, 0);
        check(exp_cnt == 2, "R7", "two features with parameters", exp_cnt, 2);

        // start while busy is ignored (R1)
        run_walk(64'h20000, "R1", 1, 64'h1000);
        bp_mode = 0;

        // bad version after one feature (R9)
        mem.delete();
        mem[64'h3000] = hw(3, 0, 0, 'h80, 0, 'h1);
        mem[64'h3080] = hw(3, 2, 0, 'h80, 0, 'h2);
        run_walk(64'h3000, "R9", 0, 0);

        // zero next without end-of-list (R10)
        mem.delete();
        mem[64'h4000] = hw(3, 0, 0, 0, 0, 'h3);
        run_walk(64'h4000, "R10", 0, 0);

        // zero parameter next without end bit (R10)
        mem.delete();
        mem[64'h4800] = hw(5, 1, 1, 'h100, 0, 'h4);
        mem[64'h4818] = 64'h1000;
        mem[64'h4820] = 64'h8000_0000;
        mem[64'h4828] = pw(0, 0, 1, 9);
        run_walk(64'h4800, "R10", 0, 0);

        // limit reached (R11), then a chain that ends exactly at the limit
        mem.delete();
        for (int i = 0; i < 6; i++) mem[64'h5000 + 64'(i * 'h40)] = hw(3, 0, 0, 'h40, 0, i);
        run_walk(64'h5000, "R11", 0, 0);
        check(exp_err && exp_cnt == MAXF, "R11", "limit outcome", exp_cnt, MAXF);
        mem[64'h50C0] = hw(3, 0, 1, 'h40, 0, 3);
        bp_mode = 1;
        run_walk(64'h5000, "R11", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule